// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block produces the word address sequence and the ready indication for one synchronous burst read from a memory array. A burst begins when a start strobe is sampled while the chip is enabled. The block captures the start address and the current configuration, waits a programmable number of clocks for the first access, and then presents one word address per clock together with a beat-valid flag. The read-data path of the array is outside the block. It uses the address and beat-valid flag to return data, and the host uses the ready output to know when data can be taken.

A configuration write places three fields on the `cfg_addr` lines. These are a burst mode (one of five), an initial latency in clocks, and an early-ready bit. Wrap bursts stay inside an aligned 8- or 16-word group. No-wrap bursts run straight across group edges. Continuous bursts never end on their own. In continuous and no-wrap bursts, a beat that lands on a 16-word line boundary is delayed by one empty clock. For that beat, ready is aligned to the data even when early ready is selected.

Top module: `burst_read_seq`

## Requirements
- R1: The mode field is `cfg_addr[2:0]`. The codes are 0 continuous, 1 wrap-8, 2 wrap-16, 3 no-wrap-8 and 4 no-wrap-16. A configuration write with a mode code of 5, 6 or 7 leaves the mode unchanged, and the other fields of that write are still taken.
- R2: In a wrap-8 or wrap-16 burst, exactly 8 or 16 beats are issued. Each beat address is the start address plus the beat index, reduced within the aligned group (start 2 in wrap-8 gives 2,3,4,5,6,7,0,1).
- R3: In a no-wrap-8 or no-wrap-16 burst, exactly 8 or 16 beats carry consecutive addresses from the start address, crossing group edges (start 2 in no-wrap-16 ends at 17).
- R4: In a continuous burst, the address increments by one per beat with no limit until the burst is aborted or restarted.
- R5: The latency field is `cfg_addr[11:8]` and holds W, with legal values 2 to 15. A write with W of 0 or 1 leaves the latency unchanged. After reset W is 7. If the start strobe is sampled at clock edge E, the first beat is valid after edge E+W.
- R6: With early ready off, `rdy` equals `beat_vld` in every cycle.
- R7: Early ready is enabled by `cfg_addr[18]`. When it is on, `rdy` is high in the cycle before each valid beat and low otherwise, except as stated in R8.
- R8: In continuous and no-wrap bursts, a beat other than the first whose address has its low four bits at zero is preceded by one cycle without a beat. In early mode, `rdy` for that beat rises in the same cycle as the beat.
- R9: If `chip_en` is sampled low, the next cycle shows `beat_vld` and `rdy` low, and no further beats follow. A start strobe sampled during a burst abandons that burst and begins a new latency count.
- R10: Mode, latency and early ready are captured at the start strobe. A configuration write during a burst does not change that burst and applies to the next one.
- R11: After reset, `beat_vld` and `rdy` are low, the mode is continuous and early ready is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration value carried on the address lines |
| chip_en | input | 1 | Chip enable, active high; low aborts a burst |
| start_vld | input | 1 | Burst start strobe, captures `start_addr` |
| start_addr | input | ADDR_W | Word address of the first beat |
| rd_addr | output | ADDR_W | Word address of the current beat |
| beat_vld | output | 1 | The current cycle carries a valid beat |
| rdy | output | 1 | Ready indication to the host |

## Verification
The hardest case to reach is early ready across a line boundary. It needs a continuous or no-wrap burst with early mode on, started a few words before a 16-word line edge, and then the stall cycle and the coincident ready must land on the correct clock. The stimulus places the low bits of random start addresses near the line end on purpose. Directed bursts start at offsets 0x0E and 0x05 in early and normal modes. A mid-burst configuration write and a restart three clocks into a burst cover capture-at-start behaviour and the fresh latency count.

// File: rtl/burst_seq_pkg.sv
// Package: shared types and helpers for the burst read sequencer.
// Assumes 16-word long groups and 8-word short groups.
package burst_seq_pkg;

    typedef enum logic [2:0] {
        BM_CONT   = 3'd0,
        BM_WRAP8  = 3'd1,
        BM_WRAP16 = 3'd2,
        BM_LIN8   = 3'd3,
        BM_LIN16  = 3'd4
    } burst_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DATA  = 2'd2,
        ST_STALL = 2'd3
    } seq_state_e;

    localparam int LONG_LOG2  = 4;
    localparam int SHORT_LOG2 = 3;

    // True for the two wrapping modes.
    function automatic logic is_wrap(input burst_mode_e m);
        return (m == BM_WRAP8) || (m == BM_WRAP16);
    endfunction

    // True for every mode with a fixed beat count.
    function automatic logic is_bounded(input burst_mode_e m);
        return m != BM_CONT;
    endfunction

    // Beat count minus one for the bounded modes.
    function automatic logic [LONG_LOG2-1:0] len_m1(input burst_mode_e m);
        if ((m == BM_WRAP8) || (m == BM_LIN8))
            return LONG_LOG2'((1 << SHORT_LOG2) - 1);
        return LONG_LOG2'((1 << LONG_LOG2) - 1);
    endfunction

endpackage

// File: rtl/burst_cfg_regs.sv
// Configuration register for the burst read sequencer.
// Decodes the mode, latency and early-ready fields from the configuration
// word. Each field is validated on its own, and an illegal value keeps the
// previous setting. Assumes ADDR_W is wide enough to hold EARLY_BIT.
module burst_cfg_regs
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int WAIT_W    = 4,
    parameter int MODE_LSB  = 0,
    parameter int WAIT_LSB  = 8,
    parameter int EARLY_BIT = 18,
    parameter int WAIT_RST  = 7,
    parameter int WAIT_MIN  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    output burst_mode_e       mode,
    output logic [WAIT_W-1:0] wait_cyc,
    output logic              early
);

    logic [2:0]        mode_raw;
    logic [WAIT_W-1:0] wait_raw;
    logic              unused_cfg_bits;

    assign mode_raw        = cfg_addr[MODE_LSB +: 3];
    assign wait_raw        = cfg_addr[WAIT_LSB +: WAIT_W];
    assign unused_cfg_bits = ^cfg_addr;

    // Update each field on a write when its new value is legal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= BM_CONT;
            wait_cyc <= WAIT_W'(WAIT_RST);
            early    <= 1'b0;
        end else if (cfg_we) begin
            if (mode_raw <= 3'(BM_LIN16))
                mode <= burst_mode_e'(mode_raw);
            if (wait_raw >= WAIT_W'(WAIT_MIN))
                wait_cyc <= wait_raw;
            early <= cfg_addr[EARLY_BIT];
        end
    end

    AST_WAIT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cyc >= WAIT_W'(WAIT_MIN)); // R5
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && (mode_raw > 3'(BM_LIN16)) |=> $stable(mode)); // R1

endmodule

// File: rtl/burst_addr_step.sv
// Combinational address stepper.
// Returns the address of the next beat for the given mode. It also flags
// when a non-wrapping step lands on a line boundary of 2**LINE_W words.
// Wrap modes never report a crossing.
module burst_addr_step
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LINE_W = LONG_LOG2
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  burst_mode_e       mode,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic              nxt_cross
);

    localparam logic [ADDR_W-1:0] MASK_S = ADDR_W'((1 << SHORT_LOG2) - 1);
    localparam logic [ADDR_W-1:0] MASK_L = ADDR_W'((1 << LINE_W) - 1);

    logic [ADDR_W-1:0] inc;

    assign inc = cur_addr + ADDR_W'(1);

    // Select the wrapped or straight increment.
    always_comb begin
        unique case (mode)
            BM_WRAP8:  nxt_addr = (cur_addr & ~MASK_S) | (inc & MASK_S);
            BM_WRAP16: nxt_addr = (cur_addr & ~MASK_L) | (inc & MASK_L);
            default:   nxt_addr = inc;
        endcase
    end

    // Flag a line-boundary landing for non-wrapping modes.
    always_comb begin
        nxt_cross = !is_wrap(mode) && (inc[LINE_W-1:0] == '0);
    end

endmodule

// File: rtl/burst_ctrl.sv
// Burst sequencing FSM.
// Captures the start address and the configuration at the start strobe,
// counts the initial latency, and steps the beat address. It inserts one
// empty cycle before a line-crossing beat and derives ready, either aligned
// to the beat or one cycle early. Assumes the latency is at least 2.
module burst_ctrl
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int WAIT_W = 4,
    parameter int LINE_W = LONG_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              start_vld,
    input  logic [ADDR_W-1:0] start_addr,
    input  burst_mode_e       cfg_mode,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              cfg_early,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              beat_vld,
    output logic              rdy
);

    seq_state_e        state_q;
    logic [WAIT_W-1:0] wcnt_q;
    logic [LINE_W-1:0] left_q;
    logic [ADDR_W-1:0] addr_q;
    burst_mode_e       mode_q;
    logic              early_q;
    logic              cross_q;
    logic [ADDR_W-1:0] step_addr;
    logic              step_cross;
    logic              last_beat;
    logic              rdy_early;

    burst_addr_step #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_step (
        .cur_addr  (addr_q),
        .mode      (mode_q),
        .nxt_addr  (step_addr),
        .nxt_cross (step_cross)
    );

    assign last_beat = is_bounded(mode_q) && (left_q == '0);

    // Run the burst state machine and its counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wcnt_q  <= '0;
            left_q  <= '0;
            addr_q  <= '0;
            mode_q  <= BM_CONT;
            early_q <= 1'b0;
            cross_q <= 1'b0;
        end else if (chip_en && start_vld) begin
            state_q <= ST_WAIT;
            wcnt_q  <= cfg_wait - WAIT_W'(1);
            left_q  <= LINE_W'(len_m1(cfg_mode));
            addr_q  <= start_addr;
            mode_q  <= cfg_mode;
            early_q <= cfg_early;
            cross_q <= 1'b0;
        end else if (!chip_en) begin
            state_q <= ST_IDLE;
            cross_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_WAIT: begin
                    if (wcnt_q == '0)
                        state_q <= ST_DATA;
                    else
                        wcnt_q <= wcnt_q - WAIT_W'(1);
                end
                ST_DATA: begin
                    cross_q <= 1'b0;
                    if (last_beat) begin
                        state_q <= ST_IDLE;
                    end else begin
                        addr_q  <= step_addr;
                        left_q  <= left_q - LINE_W'(1);
                        state_q <= step_cross ? ST_STALL : ST_DATA;
                    end
                end
                ST_STALL: begin
                    state_q <= ST_DATA;
                    cross_q <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Predict a beat in the next cycle; crossing beats get coincident ready.
    always_comb begin
        rdy_early = ((state_q == ST_WAIT) && (wcnt_q == '0))
                 || ((state_q == ST_DATA) && cross_q)
                 || ((state_q == ST_DATA) && !last_beat && !step_cross);
    end

    assign beat_vld = (state_q == ST_DATA);
    assign rd_addr  = addr_q;
    assign rdy      = early_q ? rdy_early : beat_vld;

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> !beat_vld && !rdy); // R9
    AST_RESTART_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        chip_en && start_vld |=> !beat_vld); // R5
    AST_WRAP8_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld && chip_en && !start_vld && (mode_q == BM_WRAP8)
        |=> !beat_vld || (rd_addr[ADDR_W-1:3] == $past(rd_addr[ADDR_W-1:3]))); // R2
    AST_EARLY_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        rdy && !beat_vld && chip_en && !start_vld |=> beat_vld); // R7
    AST_ONE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STALL) && chip_en && !start_vld |=> beat_vld); // R8

endmodule

// File: rtl/burst_read_seq.sv
// Top of the burst read address sequencer.
// Connects the configuration register to the burst controller. The
// configuration arrives on the address lines with a write strobe, and the
// controller captures it at each burst start.
module burst_read_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int WAIT_W    = 4,
    parameter int EARLY_BIT = 18,
    parameter int WAIT_RST  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              chip_en,
    input  logic              start_vld,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              beat_vld,
    output logic              rdy
);

    burst_mode_e       mode_w;
    logic [WAIT_W-1:0] wait_w;
    logic              early_w;

    burst_cfg_regs #(
        .ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .EARLY_BIT(EARLY_BIT), .WAIT_RST(WAIT_RST)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .mode     (mode_w),
        .wait_cyc (wait_w),
        .early    (early_w)
    );

    burst_ctrl #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_en    (chip_en),
        .start_vld  (start_vld),
        .start_addr (start_addr),
        .cfg_mode   (mode_w),
        .cfg_wait   (wait_w),
        .cfg_early  (early_w),
        .rd_addr    (rd_addr),
        .beat_vld   (beat_vld),
        .rdy        (rdy)
    );

endmodule

// File: tb/tb_burst_read_seq.sv
module tb_burst_read_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int NA = 140;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic          chip_en = 1'b1;
    logic          start_vld = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] rd_addr;
    logic          beat_vld;
    logic          rdy;

    int  n_checks = 0;
    int  n_fails = 0;
    bit  done = 1'b0;

    int  m_mode = 0;
    int  m_wait = 7;
    bit  m_early = 1'b0;

    bit            ev [0:NA];
    bit            ec [0:NA];
    logic [AW-1:0] ea [0:NA];

    burst_read_seq dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .chip_en(chip_en), .start_vld(start_vld), .start_addr(start_addr),
        .rd_addr(rd_addr), .beat_vld(beat_vld), .rdy(rdy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    endtask

    function automatic logic [AW-1:0] mk_cfg(input int md, input int w, input bit e);
        return (AW'(e) << 18) | (AW'(w & 15) << 8) | AW'(md & 7);
    endfunction

    // Expected address of beat b from the requirements.
    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] sa, input int md, input int b);
        logic [AW-1:0] m;
        if (md == 1 || md == 2) begin
            m = (md == 1) ? AW'(7) : AW'(15);
            return (sa & ~m) | ((sa + AW'(b)) & m);
        end
        return sa + AW'(b);
    endfunction

    task automatic write_cfg(input int md, input int w, input bit e);
        cfg_we = 1'b1;
        cfg_addr = mk_cfg(md, w, e);
        @(negedge clk);
        cfg_we = 1'b0;
        if (md <= 4) m_mode = md;
        if ((w & 15) >= 2) m_wait = w & 15;
        m_early = e;
    endtask

    // Run one burst from the current negedge and check every cycle.
    task automatic run_burst(input logic [AW-1:0] sa, input int stop_c,
                             input bit midcfg, input int mmd, input int mw, input bit me);
        int cm = m_mode;
        int cw = m_wait;
        bit ce = m_early;
        int t;
        int last_t = 0;
        int nb;
        int end_c;
        string atag;
        string rtag;
        for (int i = 0; i <= NA; i++) begin ev[i] = 0; ec[i] = 0; ea[i] = '0; end
        nb = (cm == 0) ? 41 : ((cm == 1 || cm == 3) ? 8 : 16);
        atag = (cm == 0) ? "R4" : ((cm <= 2) ? "R2" : "R3");
        t = cw;
        for (int b = 0; b < nb; b++) begin
            logic [AW-1:0] a = beat_addr(sa, cm, b);
            if (b > 0 && !(cm == 1 || cm == 2) && a[3:0] == 4'h0) begin
                t++;
                ec[t] = 1;
            end
            ev[t] = 1;
            ea[t] = a;
            last_t = t;
            t++;
        end
        end_c = (cm == 0) ? last_t - 1 : last_t + 2;
        if (stop_c < end_c) end_c = stop_c;
        start_vld = 1'b1;
        start_addr = sa;
        @(negedge clk);
        start_vld = 1'b0;
        for (int c = 0; c <= end_c; c++) begin
            bit er;
            if (c > 0) @(negedge clk);
            if (midcfg && c == 2) begin
                cfg_we = 1'b1;
                cfg_addr = mk_cfg(mmd, mw, me);
            end
            if (midcfg && c == 3) begin
                cfg_we = 1'b0;
                if (mmd <= 4) m_mode = mmd;
                if (mw >= 2) m_wait = mw;
                m_early = me;
            end
            er = ce ? ((ev[c+1] && !ec[c+1]) || (ev[c] && ec[c])) : ev[c];
            rtag = (ec[c] || ec[c+1]) ? "R8" : (ce ? "R7" : "R6");
            chk(beat_vld == ev[c], (c == cw) ? "R5" : atag, "beat_vld", beat_vld, ev[c]);
            if (ev[c]) chk(rd_addr == ea[c], atag, "rd_addr", rd_addr, ea[c]);
            chk(rdy == er, rtag, "rdy", rdy, er);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            report();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5821));
        repeat (3) @(negedge clk);
        // R11: reset outputs
        chk(beat_vld == 1'b0, "R11", "beat_vld after reset", beat_vld, 0);
        chk(rdy == 1'b0, "R11", "rdy after reset", rdy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(beat_vld == 1'b0 && rdy == 1'b0, "R11", "idle outputs", {beat_vld, rdy}, 0);
        // R11 R5 R4 R8: reset defaults, continuous from 5 with a line crossing
        run_burst(24'h000005, 999, 0, 0, 0, 0);
        // R9: abort on chip enable
        chip_en = 1'b0;
        @(negedge clk);
        chk(beat_vld == 1'b0 && rdy == 1'b0, "R9", "abort", {beat_vld, rdy}, 0);
        chip_en = 1'b1;
        @(negedge clk);
        chk(beat_vld == 1'b0, "R9", "stays idle after abort", beat_vld, 0);
        // R2: wrap-8 from 2
        write_cfg(1, 4, 0);
        run_burst(24'h000002, 999, 0, 0, 0, 0);
        // R3 R8: no-wrap-16 from 2 ends at 17
        write_cfg(4, 3, 0);
        run_burst(24'h000002, 999, 0, 0, 0, 0);
        // R1: illegal mode code keeps no-wrap-16, latency 9 taken
        write_cfg(6, 9, 0);
        run_burst(24'h000120, 999, 0, 0, 0, 0);
        // R5: illegal latency 1 keeps 9, mode wrap-16 taken
        write_cfg(2, 1, 0);
        run_burst(24'h00003B, 999, 0, 0, 0, 0);
        // R7 R8: early ready, no-wrap-8 crossing at 0x10
        write_cfg(3, 2, 1);
        run_burst(24'h00000E, 999, 0, 0, 0, 0);
        // R7: early ready continuous crossing
        write_cfg(0, 5, 1);
        run_burst(24'h0000FD, 999, 0, 0, 0, 0);
        chip_en = 1'b0;
        @(negedge clk);
        chk(beat_vld == 1'b0 && rdy == 1'b0, "R9", "abort early mode", {beat_vld, rdy}, 0);
        chip_en = 1'b1;
        // R10: mid-burst write must not change the running burst
        write_cfg(1, 3, 0);
        run_burst(24'h000045, 999, 1, 4, 12, 1);
        run_burst(24'h00004D, 999, 0, 0, 0, 0);
        // R9: restart three cycles into a burst
        write_cfg(2, 6, 0);
        run_burst(24'h000200, 3, 0, 0, 0, 0);
        run_burst(24'h000313, 999, 0, 0, 0, 0);
        // Random bursts with start addresses biased toward line ends
        for (int k = 0; k < 40; k++) begin
            int md = $urandom_range(0, 4);
            int w = $urandom_range(2, 15);
            bit e = 1'($urandom_range(0, 1));
            logic [AW-1:0] sa = AW'($urandom);
            if ($urandom_range(0, 1) == 1) sa[3:0] = 4'($urandom_range(12, 15));
            write_cfg(md, w, e);
            run_burst(sa, (k % 7 == 3) ? 5 : 999, 0, 0, 0, 0);
            if (md == 0) begin
                chip_en = 1'b0;
                @(negedge clk);
                chk(beat_vld == 1'b0 && rdy == 1'b0, "R9", "random abort", {beat_vld, rdy}, 0);
                chip_en = 1'b1;
            end
        end
        done = 1'b1;
        report();
        $finish;
    end

endmodule